// File: doc/BRIEF.md
# Crossbar clock generator channel bank

This block holds a bank of clock output channels that share one set of source clocks. Each channel picks one source through a crossbar select field. The picked clock then passes through a pre-divider with its own gate, and then through a final divider with its own gate. The output of the final divider is the channel output. Software programs every channel through a small memory-mapped register bus. A channel is switched on by opening both gates, and switched off by closing the final gate alone. A channel counts as running only when its final gate is open.

In this model every source clock, and every channel output, is an enable strobe on one reference clock. A divider stage with divide field d sends one output strobe for every d+1 input strobes. A field of zero passes each input strobe straight through. The crossbar selects of four channels share one 32-bit word. The pre-divider and final-divider settings of each channel have a register of their own.

Top module: `xbar_clkgen_bank`

## Requirements
- R1: Channel i's crossbar select is in the word at byte offset 0x18 + 4*floor(i/4), in the 8-bit lane that starts at bit 8*(i mod 4). Lane bits [5:0] hold the source index and lane bit 6 opens the pre-divider gate. Both fields read back as written.
- R2: Channel i's pre-divider register is at offset 0x58 + 4*i. A 10-bit divide field in bits [9:0] divides the pre-divider input by field+1.
- R3: Channel i's final register is at offset 0x164 + 4*i. It holds the divide field in bits [5:0], the final gate in bit 6 and the sync-mode control in bit 7. The channel emits floor(floor(n/(p+1))/(f+1)) strobes for n source strobes after both dividers restart.
- R4: The clock path runs select, pre-gate, pre-divider, final gate, final divider. A closed gate holds its stage output low and freezes that stage's count, so with either gate closed the channel emits nothing.
- R5: Writing a zero final gate bit leaves the pre-divider gate bit unchanged. From the second clock edge after that write, the channel output stays low even while its source keeps strobing.
- R6: A channel follows only its selected source. A source index of NSRC or more selects no source, and the channel stays low.
- R7: Any write to a channel's pre-divider register or final register restarts the count of that divider from zero.
- R8: Crossbar lane bit 7, pre-divider bits [31:10] and final register bits [31:8] read as zero and ignore writes. Offsets with no register read as zero, and writes to them change no register.
- R9: Read data appears on rdata in the cycle after rd_en and is zero when the cycle before had no read. After reset every register reads zero and every channel output is low.
- R10: While a channel's final divide field is not zero, its output is never high in two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| src_stb | input | NSRC | One enable strobe per source clock |
| ch_out | output | NCH | One output strobe per channel |

## Verification
The assertions assume that a source strobe lasts one reference cycle and that register accesses have a clean address in the cycle they are strobed. They also assume that software never asks for a read and a write in the same cycle. The bench drives every strobe, and every bus access, for exactly one cycle from the falling edge. It never overlaps a read with a write, and it holds the source strobes at zero while it reprograms a channel, except in the one test that closes a gate while the source is running.

// File: rtl/xcg_pkg.sv
package xcg_pkg;
    localparam int SEL_W     = 6;
    localparam int PRE_W     = 10;
    localparam int FIN_W     = 6;
    localparam int XBAR_BASE = 'h18;
    localparam int PRE_BASE  = 'h58;
    localparam int FIN_BASE  = 'h164;

    typedef struct packed {
        logic             sync;
        logic [FIN_W-1:0] fin_div;
        logic             fin_gate;
        logic [PRE_W-1:0] pre_div;
        logic             pre_gate;
        logic [SEL_W-1:0] sel;
    } chan_cfg_t;
endpackage

// File: rtl/xcg_regs.sv
module xcg_regs
    import xcg_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int ADDR_W = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [31:0]           wdata,
    output logic [31:0]           rdata,
    output chan_cfg_t [NCH-1:0]   cfg,
    output logic [NCH-1:0]        pre_ld,
    output logic [NCH-1:0]        fin_ld
);
    typedef struct packed {
        chan_cfg_t [NCH-1:0] cfg;
        logic [31:0]         rdata;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.rdata = '0;
        pre_ld     = '0;
        fin_ld     = '0;
        for (int i = 0; i < NCH; i++) begin
            // crossbar lane: four channels share one word
            if (wr_en && addr == ADDR_W'(XBAR_BASE + 4 * (i / 4))) begin
                st_d.cfg[i].sel      = wdata[8 * (i % 4) +: SEL_W];
                st_d.cfg[i].pre_gate = wdata[8 * (i % 4) + 6];
            end
            if (wr_en && addr == ADDR_W'(PRE_BASE + 4 * i)) begin
                st_d.cfg[i].pre_div = wdata[PRE_W-1:0];
                pre_ld[i]           = 1'b1;
            end
            if (wr_en && addr == ADDR_W'(FIN_BASE + 4 * i)) begin
                st_d.cfg[i].fin_div  = wdata[FIN_W-1:0];
                st_d.cfg[i].fin_gate = wdata[6];
                st_d.cfg[i].sync     = wdata[7];
                fin_ld[i]            = 1'b1;
            end
            if (rd_en && addr == ADDR_W'(XBAR_BASE + 4 * (i / 4))) begin
                st_d.rdata[8 * (i % 4) +: 8] =
                    {1'b0, st_q.cfg[i].pre_gate, st_q.cfg[i].sel};
            end
            if (rd_en && addr == ADDR_W'(PRE_BASE + 4 * i)) begin
                st_d.rdata = {{(32 - PRE_W){1'b0}}, st_q.cfg[i].pre_div};
            end
            if (rd_en && addr == ADDR_W'(FIN_BASE + 4 * i)) begin
                st_d.rdata = {24'b0, st_q.cfg[i].sync, st_q.cfg[i].fin_gate,
                              st_q.cfg[i].fin_div};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.rdata;
    assign cfg   = st_q.cfg;
endmodule

// File: rtl/xcg_divstage.sv
module xcg_divstage #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_stb,
    input  logic         gate,
    input  logic [W-1:0] div,
    input  logic         reload,
    output logic         out_stb
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         out;
    } div_t;

    div_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.out = 1'b0;
        if (reload) begin
            st_d.cnt = '0;
        end else if (gate && in_stb) begin
            if (st_q.cnt >= div) begin
                st_d.cnt = '0;
                st_d.out = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_stb = st_q.out;
endmodule

// File: rtl/xcg_chan.sv
module xcg_chan
    import xcg_pkg::*;
#(
    parameter int NSRC = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_stb,
    input  chan_cfg_t       cfg,
    input  logic            pre_ld,
    input  logic            fin_ld,
    output logic            mid_stb,
    output logic            out_stb
);
    logic picked;

    always_comb begin
        picked = 1'b0;
        for (int s = 0; s < NSRC; s++) begin
            if (cfg.sel == SEL_W'(s)) picked = src_stb[s];
        end
    end

    xcg_divstage #(.W(PRE_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_stb  (picked),
        .gate    (cfg.pre_gate),
        .div     (cfg.pre_div),
        .reload  (pre_ld),
        .out_stb (mid_stb)
    );

    xcg_divstage #(.W(FIN_W)) u_fin (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_stb  (mid_stb),
        .gate    (cfg.fin_gate),
        .div     (cfg.fin_div),
        .reload  (fin_ld),
        .out_stb (out_stb)
    );
endmodule

// File: rtl/xbar_clkgen_bank.sv
module xbar_clkgen_bank
    import xcg_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int NSRC   = 8,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic [NSRC-1:0]   src_stb,
    output logic [NCH-1:0]    ch_out
);
    chan_cfg_t [NCH-1:0] cfg;
    logic [NCH-1:0]      pre_ld;
    logic [NCH-1:0]      fin_ld;
    logic [NCH-1:0]      mid_stb;

    xcg_regs #(.NCH(NCH), .ADDR_W(ADDR_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .addr   (addr),
        .wdata  (wdata),
        .rdata  (rdata),
        .cfg    (cfg),
        .pre_ld (pre_ld),
        .fin_ld (fin_ld)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        xcg_chan #(.NSRC(NSRC)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .src_stb (src_stb),
            .cfg     (cfg[i]),
            .pre_ld  (pre_ld[i]),
            .fin_ld  (fin_ld[i]),
            .mid_stb (mid_stb[i]),
            .out_stb (ch_out[i])
        );
    end
endmodule

// File: rtl/xcg_check.sv
module xcg_check
    import xcg_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int ADDR_W = 10
) (
    input logic                clk,
    input logic                rst_n,
    input logic                rd_en,
    input logic [ADDR_W-1:0]   addr,
    input logic [31:0]         rdata,
    input logic [NCH-1:0]      ch_out,
    input logic [NCH-1:0]      mid_stb,
    input chan_cfg_t [NCH-1:0] cfg
);
    assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr < ADDR_W'(XBAR_BASE)) |=> (rdata == '0));

    assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata[31] == 1'b0 && rdata[23] == 1'b0 && rdata[15] == 1'b0));

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        assert_fin_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
            ch_out[i] |-> $past(cfg[i].fin_gate));

        assert_path_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
            ch_out[i] |-> $past(mid_stb[i]));

        assert_pre_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
            mid_stb[i] |-> $past(cfg[i].pre_gate));

        assert_no_back_to_back_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_out[i] && cfg[i].fin_div != '0) |=> !ch_out[i]);
    end
endmodule

bind xbar_clkgen_bank xcg_check #(.NCH(NCH), .ADDR_W(ADDR_W)) u_check (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .addr    (addr),
    .rdata   (rdata),
    .ch_out  (ch_out),
    .mid_stb (mid_stb),
    .cfg     (cfg)
);

// File: tb/xbar_clkgen_bank_tb.sv
module xbar_clkgen_bank_tb;
    localparam int NCH  = 4;
    localparam int NSRC = 8;

    typedef struct packed {
        logic [7:0]  ch;
        logic [7:0]  src;
        logic [15:0] pdiv;
        logic [7:0]  fdiv;
        logic [15:0] n;
        logic [15:0] expv;
    } vec_t;

    // channel, source, pre field, final field, source strobes, expected outputs
    localparam vec_t VECS [7] = '{
        '{8'd0, 8'd0, 16'd0,  8'd0,  16'd20,  16'd20},
        '{8'd1, 8'd3, 16'd2,  8'd0,  16'd30,  16'd10},
        '{8'd2, 8'd5, 16'd0,  8'd3,  16'd40,  16'd10},
        '{8'd3, 8'd7, 16'd4,  8'd1,  16'd100, 16'd10},
        '{8'd0, 8'd2, 16'd9,  8'd4,  16'd100, 16'd2},
        '{8'd1, 8'd1, 16'd0,  8'd63, 16'd130, 16'd2},
        '{8'd2, 8'd6, 16'd65, 8'd0,  16'd200, 16'd3}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic            rd_en = 1'b0;
    logic [9:0]      addr = '0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata;
    logic [NSRC-1:0] src_stb = '0;
    logic [NCH-1:0]  ch_out;

    int checks = 0;
    int errors = 0;
    int pulses [NCH];
    logic cnt_on = 1'b0;
    logic clr = 1'b0;
    logic [31:0] xbar_sh = '0;
    logic [31:0] rd;

    always #5 clk = ~clk;

    xbar_clkgen_bank #(.NCH(NCH), .NSRC(NSRC), .ADDR_W(10)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .src_stb (src_stb),
        .ch_out  (ch_out)
    );

    always @(negedge clk) begin
        for (int i = 0; i < NCH; i++) begin
            if (clr) pulses[i] = 0;
            else if (cnt_on && ch_out[i]) pulses[i] = pulses[i] + 1;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic bus_wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic clear_pulses();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic feed(input logic [NSRC-1:0] mask, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            src_stb = mask;
        end
        @(negedge clk);
        src_stb = '0;
        repeat (6) @(negedge clk);
    endtask

    task automatic set_lane(input int ch, input logic [7:0] lane);
        xbar_sh[8 * (ch % 4) +: 8] = lane;
        bus_wr(10'h18, xbar_sh);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: reset state
        check("R9 outputs low after reset", {28'b0, ch_out}, 32'h0);
        bus_rd(10'h18, rd);  check("R9 crossbar word reset", rd, 32'h0);
        bus_rd(10'h58, rd);  check("R9 pre register reset", rd, 32'h0);
        bus_rd(10'h170, rd); check("R9 final register reset", rd, 32'h0);

        // R8: reserved bits
        bus_wr(10'h18, 32'hFFFF_FFFF);
        bus_rd(10'h18, rd);  check("R8 crossbar lane bit 7 reserved (R1 layout)", rd, 32'h7F7F_7F7F);
        bus_wr(10'h58, 32'hFFFF_FFFF);
        bus_rd(10'h58, rd);  check("R8 pre register upper bits reserved", rd, 32'h3FF);
        bus_wr(10'h164, 32'hFFFF_FFFF);
        bus_rd(10'h164, rd); check("R8 final register upper bits reserved (R3 layout)", rd, 32'hFF);
        bus_wr(10'h18, 32'h0);
        bus_wr(10'h58, 32'h0);
        bus_wr(10'h164, 32'h0);

        // R8: unmapped offsets
        bus_wr(10'h100, 32'hDEAD_BEEF);
        bus_wr(10'h1C, 32'h4545_4545);
        bus_rd(10'h100, rd); check("R8 unmapped read zero", rd, 32'h0);
        bus_rd(10'h1C, rd);  check("R8 absent crossbar word reads zero", rd, 32'h0);
        bus_rd(10'h14, rd);  check("R8 offset below map reads zero", rd, 32'h0);
        bus_rd(10'h18, rd);  check("R8 unmapped writes change no register", rd, 32'h0);

        // R1: lane placement for channel 2
        set_lane(2, 8'h45);
        bus_rd(10'h18, rd);  check("R1 channel 2 lane position", rd, 32'h0045_0000);
        set_lane(2, 8'h00);

        // vector table: R2, R3, R6
        for (int v = 0; v < 7; v++) begin
            automatic int ch = int'(VECS[v].ch);
            set_lane(ch, {2'b01, VECS[v].src[5:0]});
            bus_wr(10'(16'h58 + 4 * ch), {16'b0, VECS[v].pdiv});
            bus_wr(10'(16'h164 + 4 * ch), {24'b0, 2'b01, VECS[v].fdiv[5:0]});
            clear_pulses();
            cnt_on = 1'b1;
            feed(NSRC'(1) << VECS[v].src, int'(VECS[v].n));
            cnt_on = 1'b0;
            check($sformatf("R3 R2 vector %0d output count", v),
                  32'(pulses[ch]), {16'b0, VECS[v].expv});
            for (int o = 0; o < NCH; o++) begin
                if (o != ch)
                    check($sformatf("R6 vector %0d idle channel %0d", v, o),
                          32'(pulses[o]), 32'h0);
            end
            bus_wr(10'(16'h164 + 4 * ch), 32'h0);
        end

        // R7: restart on register write
        xbar_sh = '0;
        set_lane(0, 8'h40);
        bus_wr(10'h58, 32'h0);
        bus_wr(10'h164, 32'h43);
        clear_pulses();
        cnt_on = 1'b1;
        feed(8'h01, 3);
        bus_wr(10'h164, 32'h43);
        feed(8'h01, 3);
        cnt_on = 1'b0;
        check("R7 final divider restarts on write", 32'(pulses[0]), 32'h0);

        // R5: closing final gate while source runs
        bus_wr(10'h164, 32'h40);
        @(negedge clk);
        src_stb = 8'h01;
        repeat (4) @(negedge clk);
        bus_wr(10'h164, 32'h00);
        @(negedge clk);
        clear_pulses();
        cnt_on = 1'b1;
        repeat (8) @(negedge clk);
        cnt_on = 1'b0;
        src_stb = '0;
        check("R5 output low after final gate closes", 32'(pulses[0]), 32'h0);
        bus_rd(10'h18, rd);
        check("R5 pre gate untouched by disable", rd, 32'h40);

        // R4: pre gate closed, final gate open
        set_lane(0, 8'h00);
        bus_wr(10'h164, 32'h40);
        clear_pulses();
        cnt_on = 1'b1;
        feed(8'h01, 10);
        cnt_on = 1'b0;
        check("R4 closed pre gate blocks output", 32'(pulses[0]), 32'h0);

        // R6: out-of-range source index, and unselected sources
        set_lane(0, 8'h68);
        clear_pulses();
        cnt_on = 1'b1;
        feed('1, 10);
        cnt_on = 1'b0;
        check("R6 source index beyond NSRC gives nothing", 32'(pulses[0]), 32'h0);
        set_lane(0, 8'h42);
        clear_pulses();
        cnt_on = 1'b1;
        feed(8'hFB, 10);
        cnt_on = 1'b0;
        check("R6 unselected sources ignored", 32'(pulses[0]), 32'h0);
        clear_pulses();
        cnt_on = 1'b1;
        feed(8'h04, 5);
        cnt_on = 1'b0;
        check("R6 selected source passes", 32'(pulses[0]), 32'h5);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule